// File: doc/BRIEF.md
# Partial-Word Load Merge Unit

This block sits at the write-back end of a load path for a byte-addressed, little-endian 32-bit memory. It takes the effective address of a load, the aligned memory word that holds the addressed byte, the current contents of the destination register, and a load-kind select. From these it produces the value to write to the register and an address-error flag. Within a word, the byte at the highest address is the most significant byte.

There are three kinds of load. An ordinary word load needs an aligned address. Two partial loads, one filling the high end of the register and one filling the low end, each read only the aligned word that holds the addressed byte. Each one merges part of that word into the old register value. Software issues a high-end partial load at address a+3 and a low-end partial load at address a, in either order. Together they assemble the unaligned word that starts at byte a, and neither access crosses a word boundary.

The result passes through one register stage, so each valid request gives its result on the following clock cycle.

Top module: `lmu_merge_unit`

## Requirements
- R1: After reset, and one cycle after any cycle with `valid_i` low, `valid_o`, `wr_en_o` and `addr_err_o` are 0. After reset `wdata_o` is 0. A request with `valid_i` high gives `valid_o` high exactly one cycle later.
- R2: For a word load (`kind_i`=00) whose address has its low two bits at 00, the result is the memory word, with `wr_en_o`=1 and `addr_err_o`=0.
- R3: For a word load with nonzero low two address bits, the result has `addr_err_o`=1 and `wr_en_o`=0, and `wdata_o` equals the old register value.
- R4: For a high-end partial load (`kind_i`=01) at byte offset k (the low two address bits), word bytes k down to 0 go into the top k+1 register bytes. The remaining low register bytes keep their old values. For example, at k=2 the word 0xDDCCBBAA and the old value 0x11223344 give 0xCCBBAA44.
- R5: A high-end partial load at offset 3 returns the whole memory word.
- R6: For a low-end partial load (`kind_i`=10) at offset k, word bytes 3 down to k go into the low 4-k register bytes. The remaining high register bytes keep their old values. For example, at k=3 the word 0xDDCCBBAA and the old value 0x11223344 give 0x112233DD.
- R7: A low-end partial load at offset 0 returns the whole memory word.
- R8: Partial loads never raise `addr_err_o` and always set `wr_en_o`. Address bits above the low two have no effect on any output.
- R9: A high-end partial load at a+3 and a low-end partial load at a, with the second using the first's result as its old value, produce the little-endian word made of bytes a..a+3. This holds in either order.
- R10: `kind_i`=11 is reserved. It gives `wr_en_o`=0 and `addr_err_o`=0, and `wdata_o` equals the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 2 | Load kind: 00 word, 01 high-end partial, 10 low-end partial, 11 reserved |
| addr_i | input | 32 | Effective byte address |
| mem_word_i | input | 32 | Aligned memory word holding the addressed byte |
| reg_old_i | input | 32 | Current destination register value |
| valid_o | output | 1 | Result present, one cycle after request |
| wr_en_o | output | 1 | Register write permitted |
| addr_err_o | output | 1 | Misaligned word load |
| wdata_o | output | 32 | Value for the destination register |

## Verification
The bench drives all four offsets with both partial kinds. A design with the lane mapping reversed or shifted by one would put the wrong memory byte into a lane, or would overwrite a byte it should keep. The full-word edge cases, high-end at offset 3 and low-end at offset 0, catch an off-by-one that drops or keeps one lane too many. Misaligned word loads at each nonzero offset catch a design that flags partial loads, writes despite the error, or passes memory data through on an error. Two-step assembly of unaligned words, in both issue orders, together with random upper address bits, shows that the merges compose correctly and that only the offset bits matter.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  typedef enum logic [1:0] {
    LD_WORD  = 2'b00,
    LD_HIGH  = 2'b01,
    LD_LOW   = 2'b10,
    LD_RSVD  = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/lmu_lane_sel.sv
module lmu_lane_sel
  import lmu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IDX   = 0,
  parameter int BYTE_W = 8,
  localparam int OFFW = $clog2(LANES),
  localparam int DW   = LANES * BYTE_W
) (
  input  ld_kind_e          kind_i,
  input  logic [OFFW-1:0]   ofs_i,
  input  logic [DW-1:0]     mem_word_i,
  input  logic [BYTE_W-1:0] old_byte_i,
  output logic [BYTE_W-1:0] byte_o
);
  int src;
  logic take_mem;

  always_comb begin
    src      = IDX;
    take_mem = 1'b0;
    unique case (kind_i)
      LD_WORD: take_mem = 1'b1;
      LD_HIGH: begin
        // top ofs+1 lanes take word bytes ofs..0
        if (IDX >= LANES - 1 - int'(ofs_i)) begin
          take_mem = 1'b1;
          src      = IDX - (LANES - 1 - int'(ofs_i));
        end
      end
      LD_LOW: begin
        // low LANES-ofs lanes take word bytes LANES-1..ofs
        if (IDX + int'(ofs_i) <= LANES - 1) begin
          take_mem = 1'b1;
          src      = IDX + int'(ofs_i);
        end
      end
      default: take_mem = 1'b0;
    endcase
    byte_o = take_mem ? mem_word_i[src*BYTE_W +: BYTE_W] : old_byte_i;
  end
endmodule

// File: rtl/lmu_align_chk.sv
module lmu_align_chk
  import lmu_pkg::*;
#(
  parameter int OFFW = 2
) (
  input  ld_kind_e        kind_i,
  input  logic [OFFW-1:0] ofs_i,
  output logic            misaligned_o
);
  assign misaligned_o = (kind_i == LD_WORD) && (ofs_i != '0);
endmodule

// File: rtl/lmu_merge_unit.sv
module lmu_merge_unit
  import lmu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFFW  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] reg_old_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic              addr_err_o,
  output logic [DATA_W-1:0] wdata_o
);
  ld_kind_e          kind;
  logic [OFFW-1:0]   ofs;
  logic [DATA_W-1:0] merged;
  logic              misaligned;
  logic              err_c, wr_c;
  logic [DATA_W-1:0] data_c;
  logic              unused_addr_hi;

  assign kind = ld_kind_e'(kind_i);
  assign ofs  = addr_i[OFFW-1:0];
  assign unused_addr_hi = ^addr_i[ADDR_W-1:OFFW];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lmu_lane_sel #(.LANES(LANES), .IDX(g), .BYTE_W(BYTE_W)) u_lane (
      .kind_i     (kind),
      .ofs_i      (ofs),
      .mem_word_i (mem_word_i),
      .old_byte_i (reg_old_i[g*BYTE_W +: BYTE_W]),
      .byte_o     (merged[g*BYTE_W +: BYTE_W])
    );
  end

  lmu_align_chk #(.OFFW(OFFW)) u_align (
    .kind_i       (kind),
    .ofs_i        (ofs),
    .misaligned_o (misaligned)
  );

  assign err_c  = valid_i && misaligned;
  assign wr_c   = valid_i && !misaligned && (kind != LD_RSVD);
  assign data_c = misaligned ? reg_old_i : merged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      wr_en_o    <= 1'b0;
      addr_err_o <= 1'b0;
      wdata_o    <= '0;
    end else begin
      valid_o    <= valid_i;
      wr_en_o    <= wr_c;
      addr_err_o <= err_c;
      if (valid_i) wdata_o <= data_c;
    end
  end
endmodule

// File: rtl/lmu_merge_unit_chk.sv
module lmu_merge_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        kind_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] mem_word_i,
  input logic [DATA_W-1:0] reg_old_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic              addr_err_o,
  input logic [DATA_W-1:0] wdata_o
);
  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wr_en_o && !addr_err_o));
  assert_misaligned_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b00 && addr_i[1:0] != 2'b00)
      |=> (addr_err_o && !wr_en_o && wdata_o == $past(reg_old_i)));
  assert_aligned_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b00 && addr_i[1:0] == 2'b00)
      |=> (wr_en_o && wdata_o == $past(mem_word_i)));
  assert_high_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b01 && addr_i[1:0] == 2'b11) |=> wdata_o == $past(mem_word_i));
  assert_high_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b01 && addr_i[1:0] == 2'b00)
      |=> wdata_o[23:0] == $past(reg_old_i[23:0]));
  assert_low_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b10 && addr_i[1:0] == 2'b00) |=> wdata_o == $past(mem_word_i));
  assert_low_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b10 && addr_i[1:0] == 2'b11)
      |=> wdata_o[31:8] == $past(reg_old_i[31:8]));
  assert_partial_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind_i == 2'b01 || kind_i == 2'b10)) |=> (!addr_err_o && wr_en_o));
  assert_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'b11)
      |=> (!wr_en_o && !addr_err_o && wdata_o == $past(reg_old_i)));
endmodule

bind lmu_merge_unit lmu_merge_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .kind_i     (kind_i),
  .addr_i     (addr_i),
  .mem_word_i (mem_word_i),
  .reg_old_i  (reg_old_i),
  .valid_o    (valid_o),
  .wr_en_o    (wr_en_o),
  .addr_err_o (addr_err_o),
  .wdata_o    (wdata_o)
);

// File: tb/lmu_merge_unit_bench.sv
module lmu_merge_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic [31:0] addr_i = '0;
  logic [31:0] mem_word_i = '0;
  logic [31:0] reg_old_i = '0;
  logic        valid_o, wr_en_o, addr_err_o;
  logic [31:0] wdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mem_bytes [16];

  always #10 clk_i = ~clk_i;

  lmu_merge_unit u_lmu_merge_unit (
    .clk_i, .rst_ni, .valid_i, .kind_i, .addr_i, .mem_word_i, .reg_old_i,
    .valid_o, .wr_en_o, .addr_err_o, .wdata_o
  );

  function automatic logic [31:0] ref_data(int kind, int k, logic [31:0] mem, logic [31:0] old);
    logic [31:0] r = old;
    if (kind == 0 && k != 0) return old;
    for (int j = 0; j < 4; j++) begin
      if (kind == 0) r[j*8 +: 8] = mem[j*8 +: 8];
      else if (kind == 1 && j >= 3 - k) r[j*8 +: 8] = mem[(j-(3-k))*8 +: 8];
      else if (kind == 2 && j + k <= 3) r[j*8 +: 8] = mem[(j+k)*8 +: 8];
    end
    return r;
  endfunction

  function automatic string tag_of(int kind, int k);
    if (kind == 0) return (k == 0) ? "R2" : "R3";
    if (kind == 1) return (k == 3) ? "R5" : "R4/R8";
    if (kind == 2) return (k == 0) ? "R7" : "R6/R8";
    return "R10";
  endfunction

  task automatic check(string tag, logic [34:0] act, logic [34:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual={v,we,err,data}=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives, waits one cycle, compares at next negedge
  task automatic step(logic v, int kind, logic [31:0] addr, logic [31:0] mem,
                      logic [31:0] old, output logic [31:0] res);
    int k = int'(addr[1:0]);
    logic [31:0] ed;
    logic ewe, eerr;
    logic [31:0] prev = wdata_o;
    valid_i = v; kind_i = 2'(kind); addr_i = addr; mem_word_i = mem; reg_old_i = old;
    ed   = v ? ref_data(kind, k, mem, old) : prev;
    ewe  = v && !(kind == 0 && k != 0) && kind != 3;
    eerr = v && kind == 0 && k != 0;
    @(negedge clk_i);
    check(v ? tag_of(kind, k) : "R1", {valid_o, wr_en_o, addr_err_o, wdata_o},
          {v, ewe, eerr, ed});
    res = wdata_o;
  endtask

  function automatic logic [31:0] word_at(int wa);
    return {mem_bytes[wa+3], mem_bytes[wa+2], mem_bytes[wa+1], mem_bytes[wa]};
  endfunction

  initial begin
    logic [31:0] r, r2, expw;
    for (int i = 0; i < 16; i++) mem_bytes[i] = 8'(8'h30 + i * 7);
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check("R1", {valid_o, wr_en_o, addr_err_o, wdata_o}, 35'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R4/R6 worked examples
    step(1, 1, 32'h0000_1002, 32'hDDCCBBAA, 32'h11223344, r);
    check("R4", {3'b0, r}, {3'b0, 32'hCCBBAA44});
    step(1, 2, 32'h0000_1003, 32'hDDCCBBAA, 32'h11223344, r);
    check("R6", {3'b0, r}, {3'b0, 32'h112233DD});
    // all kinds, all offsets
    for (int kd = 0; kd < 4; kd++)
      for (int k = 0; k < 4; k++)
        step(1, kd, 32'hA5A5_0000 | 32'(k), 32'h8877_6655, 32'h0102_0304, r);
    // R1 idle cycles
    step(0, 0, 32'h1, 32'hFFFF_FFFF, 32'h0, r);
    step(0, 1, 32'h3, 32'hFFFF_FFFF, 32'h0, r);
    // R9 two-step unaligned assembly, both orders
    for (int a = 1; a < 12; a++) begin
      expw = {mem_bytes[a+3], mem_bytes[a+2], mem_bytes[a+1], mem_bytes[a]};
      step(1, 2, 32'(a), word_at(a & ~3), 32'hDEAD_BEEF, r);
      step(1, 1, 32'(a + 3), word_at((a + 3) & ~3), r, r2);
      check("R9", {3'b0, r2}, {3'b0, expw});
      step(1, 1, 32'(a + 3), word_at((a + 3) & ~3), 32'h0BAD_F00D, r);
      step(1, 2, 32'(a), word_at(a & ~3), r, r2);
      check("R9", {3'b0, r2}, {3'b0, expw});
    end
    // random mix, upper address bits random (R8)
    for (int i = 0; i < 300; i++)
      step(1'($urandom_range(0, 7) != 0), $urandom_range(0, 3), $urandom,
           $urandom, $urandom, r);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule